// File: doc/BRIEF.md
# Converter Host Frame Controller

This block sits on the host side of a serial sampling converter that runs in a self-clocked mode. The block starts each conversion by pulsing an active-low start line. In that mode the converter produces its own frame strobe and serial clock. While a frame is active, the block shifts in the 16-bit result of the current conversion. In the same frame it shifts out a 16-bit command, which the converter applies to the next conversion.

All converter-side timing is enforced by the block itself. The start pulse is held low for a parameterised number of host cycles. After the busy line falls, a guard interval must pass before the next start; this gives the converter's track-and-hold time to acquire. A start request made during a conversion or during the guard is held back until it is legal, and it is not lost. The serial inputs come from another clock domain, so they pass through a synchronizer and the host clock oversamples the serial clock. Each received word appears on a valid/data output. A frame with the wrong number of clock edges raises an error pulse instead of a result.

Top module: `cnv_host_ctrl`

## Requirements
- R1: During and after reset: `conv_start_n` is 1, `ser_out` is 0, `res_valid` and `frame_err` are 0, and `cmd_ready` is 1.
- R2: Each accepted start drives `conv_start_n` low for exactly PULSE_CYC host cycles.
- R3: `conv_start_n` does not fall from the moment a start is issued until GUARD_CYC or more host cycles after the busy input has fallen. A `start_req` that is held high during that time is served once the guard interval has passed.
- R4: While `frame_n` is low, each falling edge of `ser_clk` samples one bit of `ser_in`, most significant bit first. When `frame_n` rises after exactly 16 such edges, `res_valid` pulses for one cycle and `res_data` holds the 16 sampled bits.
- R5: `ser_out` shows bit 15 of the outgoing word from the start of the frame. It moves to the next lower bit after each rising edge of `ser_clk`, so the converter reads bit 15-k on rising edge k (k = 0..15).
- R6: A command accepted on `cmd_valid` while `cmd_ready` is high is held in a one-entry slot. `cmd_ready` stays low from acceptance until the next frame starts, and that frame shifts the command out. If the slot is empty when a frame starts, the frame shifts out all zeros.
- R7: If `frame_n` rises after fewer than 16 falling edges, or if a 17th falling edge occurs within one frame, `frame_err` pulses for one cycle. In that case `res_valid` stays low and `res_data` keeps its previous value.
- R8: `ser_out` is 0 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Level request for a conversion start |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 16 | Command word for the next frame |
| cmd_ready | output | 1 | Command slot empty |
| res_valid | output | 1 | One-cycle strobe for a received word |
| res_data | output | 16 | Last correctly framed result |
| frame_err | output | 1 | One-cycle strobe for a malformed frame |
| conv_start_n | output | 1 | Active-low conversion start to the converter |
| busy | input | 1 | Converter conversion-in-progress flag |
| frame_n | input | 1 | Active-low frame strobe from the converter |
| ser_clk | input | 1 | Serial clock from the converter |
| ser_in | input | 1 | Serial result bits from the converter |
| ser_out | output | 1 | Serial command bits to the converter |

## Verification
The bench builds the block with PULSE_CYC = 4 and GUARD_CYC = 10. This keeps each conversion to a few hundred cycles, so many back-to-back conversions fit in one run and the start-to-guard spacing is measured on every one of them. The model converter runs its serial clock at ten host cycles per period. That lets the two-stage synchronizer latency, the order of edges and the framing faults (short frames and 17-edge frames) all be observed at the ports.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOW     = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_WAIT_LO = 2'd3
  } start_st_t;
endpackage

// File: rtl/cnv_sync.sv
module cnv_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cnv_start_timer.sv
module cnv_start_timer
  import cnv_pkg::*;
#(
  parameter int PULSE_CYC = 13,
  parameter int GUARD_CYC = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic busy_s,
  output logic conv_start_n
);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam int GCW = $clog2(GUARD_CYC + 1);

  start_st_t      st;
  logic [PCW-1:0] pcnt;
  logic [GCW-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      pcnt         <= '0;
      gcnt         <= '0;
      conv_start_n <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (gcnt != '0) begin
            gcnt <= gcnt - 1'b1;
          end else if (start_req) begin
            conv_start_n <= 1'b0;
            pcnt         <= PCW'(PULSE_CYC - 1);
            st           <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (pcnt == '0) begin
            conv_start_n <= 1'b1;
            st           <= ST_WAIT_HI;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        ST_WAIT_HI: if (busy_s) st <= ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (!busy_s) begin
            st   <= ST_IDLE;
            gcnt <= GCW'(GUARD_CYC);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: no start edge while the acquisition guard is counting
  a_r3_guard_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && gcnt != '0) |=> conv_start_n);

  // R3: no start edge while waiting for the conversion to finish
  a_r3_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_HI || st == ST_WAIT_LO) |=> conv_start_n);

  generate
    if (PULSE_CYC > 1) begin : g_pulse_chk
      // R2: a start pulse is never a single cycle when more are required
      a_r2_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_start_n) |=> !conv_start_n);
    end
  endgenerate
endmodule

// File: rtl/cnv_frame_engine.sv
module cnv_frame_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_n_s,
  input  logic         ser_clk_s,
  input  logic         ser_in_s,
  input  logic         cmd_valid,
  input  logic [W-1:0] cmd_data,
  output logic         cmd_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         frame_err,
  output logic         ser_out
);
  localparam int CW = $clog2(W + 1);

  logic          fr_q, ck_q, in_frame, overrun, pend_v;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sh, tx_sh, pend;

  wire fr_fall = fr_q & ~frame_n_s;
  wire fr_rise = ~fr_q & frame_n_s;
  wire ck_rise = ~ck_q & ser_clk_s;
  wire ck_fall = ck_q & ~ser_clk_s;
  wire accept  = cmd_valid & ~pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_q <= 1'b1;
      ck_q <= 1'b0;
    end else begin
      fr_q <= frame_n_s;
      ck_q <= ser_clk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend   <= '0;
    end else begin
      if (fr_fall) pend_v <= 1'b0;
      if (accept) begin
        pend_v <= 1'b1;
        pend   <= cmd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      overrun   <= 1'b0;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      frame_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      frame_err <= 1'b0;
      if (fr_fall) begin
        in_frame <= 1'b1;
        overrun  <= 1'b0;
        cnt      <= '0;
        tx_sh    <= pend_v ? pend : '0;
      end else if (in_frame) begin
        if (fr_rise) begin
          in_frame <= 1'b0;
          tx_sh    <= '0;
          if (overrun || cnt != CW'(W)) begin
            frame_err <= 1'b1;
          end else begin
            res_valid <= 1'b1;
            res_data  <= rx_sh;
          end
        end else begin
          if (ck_fall) begin
            if (cnt == CW'(W)) overrun <= 1'b1;
            else begin
              rx_sh <= {rx_sh[W-2:0], ser_in_s};
              cnt   <= cnt + 1'b1;
            end
          end
          if (ck_rise) tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
      end
    end
  end

  assign cmd_ready = ~pend_v;
  assign ser_out   = tx_sh[W-1];

  // R4: a result strobe never lasts two cycles
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R7: a frame ends either good or bad, never both
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && frame_err));
  // R7: the bit counter never passes the word width
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W));
  // R8: serial output idles low between frames
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_frame |-> !ser_out);
  // R6: a held command stays intact until a frame takes it
  a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !fr_fall) |=> $stable(pend));
endmodule

// File: rtl/cnv_host_ctrl.sv
module cnv_host_ctrl #(
  parameter int W           = 16,
  parameter int PULSE_CYC   = 13,
  parameter int GUARD_CYC   = 42,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  input  logic         cmd_valid,
  input  logic [W-1:0] cmd_data,
  output logic         cmd_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         frame_err,
  output logic         conv_start_n,
  input  logic         busy,
  input  logic         frame_n,
  input  logic         ser_clk,
  input  logic         ser_in,
  output logic         ser_out
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, synced;

  assign raw_in = {busy, frame_n, ser_clk, ser_in};

  cnv_sync #(
    .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  cnv_start_timer #(
    .PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start_req(start_req),
    .busy_s(synced[3]), .conv_start_n(conv_start_n)
  );

  cnv_frame_engine #(.W(W)) u_frame (
    .clk(clk), .rst(rst),
    .frame_n_s(synced[2]), .ser_clk_s(synced[1]), .ser_in_s(synced[0]),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .res_valid(res_valid), .res_data(res_data), .frame_err(frame_err),
    .ser_out(ser_out)
  );
endmodule

// File: tb/tb_cnv_host_ctrl.sv
module tb_cnv_host_ctrl;
  localparam int W     = 16;
  localparam int PULSE = 4;
  localparam int GUARD = 10;
  localparam int H     = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic start_req = 1'b0, cmd_valid = 1'b0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_ready, res_valid, frame_err, conv_start_n, ser_out;
  logic [W-1:0] res_data;
  logic busy = 1'b0, frame_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, nfall = 0, fall_cyc = 0, width = 0;
  int last_busy_fall = -1;
  logic [W-1:0] last_good = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cnv_host_ctrl #(.W(W), .PULSE_CYC(PULSE), .GUARD_CYC(GUARD)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .res_valid(res_valid),
    .res_data(res_data), .frame_err(frame_err), .conv_start_n(conv_start_n),
    .busy(busy), .frame_n(frame_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .ser_out(ser_out)
  );

  always @(posedge clk) cyc++;
  always @(negedge conv_start_n) begin nfall++; fall_cyc = cyc; end
  always @(posedge conv_start_n) width = cyc - fall_cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // expected outgoing word: the accepted command or zeros (R6)
  function automatic logic [W-1:0] exp_tx(input bit has_cmd, input logic [W-1:0] c);
    return has_cmd ? c : '0;
  endfunction

  task automatic do_conv(input logic [W-1:0] word, input int nedges,
                         input bit has_cmd, input logic [W-1:0] cmd);
    int k;
    int nv;
    int ne;
    logic [W-1:0] got_rx;
    logic [W-1:0] got_tx;
    k = nfall;
    got_tx = '0;
    got_rx = '0;
    if (has_cmd) begin
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = cmd;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R6 slot busy after accept", int'(cmd_ready), 0);
    end
    start_req = 1'b1;
    wait (nfall == k + 1);
    @(negedge clk);
    start_req = 1'b0;
    busy = 1'b1;
    if (last_busy_fall >= 0)
      chk(fall_cyc - last_busy_fall >= GUARD, "R3 guard after busy fall",
          fall_cyc - last_busy_fall, GUARD);
    wait (conv_start_n == 1'b1);
    @(negedge clk);
    chk(width == PULSE, "R2 start pulse width", width, PULSE);
    repeat (4) @(negedge clk);
    // converter-driven frame
    frame_n = 1'b0;
    ser_in  = word[W-1];
    repeat (H) @(negedge clk);
    for (int e = 0; e < nedges; e++) begin
      ser_clk = 1'b1;
      if (e < W) got_tx[W-1-e] = ser_out;
      if (e > 0) ser_in = (e < W) ? word[W-1-e] : 1'b0;
      repeat (H) @(negedge clk);
      ser_clk = 1'b0;
      repeat (H) @(negedge clk);
    end
    frame_n = 1'b1;
    nv = 0;
    ne = 0;
    repeat (8) begin
      @(negedge clk);
      if (res_valid) begin nv++; got_rx = res_data; end
      if (frame_err) ne++;
    end
    if (nedges == W) begin
      chk(nv == 1, "R4 one result strobe", nv, 1);
      chk(ne == 0, "R7 no error on good frame", ne, 0);
      chk(got_rx == word, "R4 received word", int'(got_rx), int'(word));
      chk(got_tx == exp_tx(has_cmd, cmd), "R5 R6 shifted command",
          int'(got_tx), int'(exp_tx(has_cmd, cmd)));
      last_good = word;
    end else begin
      chk(ne == 1, "R7 framing error strobe", ne, 1);
      chk(nv == 0, "R7 no result on bad frame", nv, 0);
      chk(res_data == last_good, "R7 result kept", int'(res_data), int'(last_good));
    end
    chk(ser_out == 1'b0, "R8 idle serial output", int'(ser_out), 0);
    chk(cmd_ready == 1'b1, "R6 slot freed by frame", int'(cmd_ready), 1);
    // request while converter still busy: must be held back (R3)
    start_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(nfall == k + 1, "R3 start held while busy", nfall, k + 1);
    busy = 1'b0;
    last_busy_fall = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(conv_start_n == 1'b1, "R1 reset start line", int'(conv_start_n), 1);
    chk(ser_out == 1'b0, "R1 reset serial out", int'(ser_out), 0);
    chk(res_valid == 1'b0 && frame_err == 1'b0, "R1 reset strobes",
        int'({res_valid, frame_err}), 0);
    chk(cmd_ready == 1'b1, "R1 reset slot empty", int'(cmd_ready), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(conv_start_n == 1'b1, "R1 idle after reset", int'(conv_start_n), 1);

    do_conv(16'h8001, 16, 1'b1, 16'hA5C3);
    do_conv(16'hFFFF, 16, 1'b0, 16'h0000);
    do_conv(16'h1234, 10, 1'b1, 16'h7E01);
    do_conv(16'h0F0F, 17, 1'b0, 16'h0000);
    do_conv(16'h0000, 16, 1'b1, 16'hFFFF);
    for (int i = 0; i < 18; i++) begin
      logic [W-1:0] w;
      logic [W-1:0] c;
      int r;
      int ne;
      w = W'($urandom);
      c = W'($urandom);
      r = int'($urandom % 8);
      ne = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      do_conv(w, ne, ($urandom % 3) != 0, c);
    end
    start_req = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule